// File: doc/BRIEF.md
# Bit-Serial Signed-Digit Constant Multiplier

This block multiplies a two's-complement word, delivered one bit per clock with the least significant bit first, by a single positive constant fixed at elaboration time. The constant is rewritten as a canonic signed-digit string, with digits in {-1, 0, +1} and never two nonzero digits side by side. It is then built as a Horner chain. Each nonzero digit below the top one gets one bit-serial adder or subtractor. Each step between neighbouring nonzero digit positions is a run of single flip-flops, one per bit position.

A word begins with a one-cycle `word_start` pulse that arrives together with the input's least significant bit. The frame that follows lasts `DATA_W + COEF_W + 1` cycles. For the first `DATA_W` cycles the input bits are taken from `ser_in`. For the remaining cycles the block repeats the captured sign bit on its own, so `ser_in` is ignored there. The product leaves on `prod_out`, least significant bit first, one cycle behind the input. `prod_first` marks the product's bit 0 and `prod_valid` covers the whole product word. A new `word_start` may come on the cycle right after the last frame cycle. It may also come in the middle of a frame, which drops the word that was in progress.

Top module: `csd_serial_mult`

## Requirements
- R1: With `rst` high (synchronous, active high), `prod_out`, `prod_first` and `prod_valid` are 0 after the next clock edge. They stay 0 after reset until the first `word_start`, whatever `ser_in` does.
- R2: Frame cycle 0 is the cycle in which `word_start` is high, and it carries input bit 0. Product bit k leaves on `prod_out` one cycle after frame cycle k. `prod_first` is high exactly on the cycle that carries product bit 0, which is the cycle after `word_start`.
- R3: `prod_valid` is high for exactly OUT_W = DATA_W + COEF_W + 1 consecutive cycles, starting with `prod_first`, unless a new word starts. `prod_out` is 0 whenever `prod_valid` is low.
- R4: The OUT_W product bits equal x * COEF as an OUT_W-bit two's-complement number, where x is the DATA_W-bit signed input word.
- R5: `ser_in` in frame cycles DATA_W to OUT_W-1 has no effect on the product. Input bit DATA_W-1 is used as the sign for those cycles.
- R6: Words may follow back to back, with `word_start` on the cycle after the last frame cycle. Each product is exact whatever word came before. At every word start, subtractor carries restart at 1 and adder carries restart at 0, and the shifted stages read as 0 until their shift distance has elapsed.
- R7: A `word_start` inside a running frame abandons the old word. That word never completes a full OUT_W-bit product. `prod_first` marks the new word's bit 0 and the new product is exact.
- R8: The extreme coefficients are handled. COEF = 1 uses no adder, COEF = 4095 uses one subtractor across a 12-flip-flop shift, and COEF = 2813 (recoded as +2^12 -2^10 -2^8 -2^2 +2^0) uses four adder/subtractors. All three give exact products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_start | input | 1 | High for one cycle, together with input bit 0 of a word |
| ser_in | input | 1 | Serial two's-complement input, LSB first |
| prod_out | output | 1 | Serial product, LSB first |
| prod_first | output | 1 | High with product bit 0 |
| prod_valid | output | 1 | High while product bits are on `prod_out` |

## Verification
Restarting the carries and the shift stages for a new word falls in the same cycle as the previous word's data still sitting in those flip-flops. This happens whenever a word start follows the last frame cycle at once, or cuts a frame short. The bench provokes it with back-to-back words of opposite extreme signs, so the shift stages are full of the old sign bits, and with an early restart after a few cycles. It judges the outcome by comparing every completed product with the exact signed multiply, for three coefficients at once. It also checks that the abandoned word yields no complete product.

// File: rtl/csdm_pkg.sv
package csdm_pkg;

  localparam int CSD_MAXD = 32;

  // Recode a positive constant into signed digits: {negative mask, positive mask}.
  // Odd remainders pick +1 when the value is 1 mod 4 and -1 when 3 mod 4,
  // which leaves the next digit zero and so never places two nonzero digits side by side.
  function automatic logic [2*CSD_MAXD-1:0] csd_recode(input int unsigned coef);
    logic [CSD_MAXD-1:0] pm;
    logic [CSD_MAXD-1:0] nm;
    longint v;
    pm = '0;
    nm = '0;
    v  = longint'(coef);
    for (int i = 0; i < CSD_MAXD; i++) begin
      if (v[0]) begin
        if (!v[1]) begin
          pm[i] = 1'b1;
          v     = v - 1;
        end else begin
          nm[i] = 1'b1;
          v     = v + 1;
        end
      end
      v = v >>> 1;
    end
    return {nm, pm};
  endfunction

  // Number of nonzero digits; the adder count is this minus one.
  function automatic int csd_terms(input int unsigned coef);
    logic [2*CSD_MAXD-1:0] r;
    r = csd_recode(coef);
    return $countones(r);
  endfunction

  // Bit position of the k-th nonzero digit, counting from the most significant one.
  function automatic int csd_nth_pos(input int unsigned coef, input int k);
    logic [2*CSD_MAXD-1:0] r;
    logic [CSD_MAXD-1:0]   nz;
    int n;
    int res;
    r   = csd_recode(coef);
    nz  = r[2*CSD_MAXD-1:CSD_MAXD] | r[CSD_MAXD-1:0];
    n   = 0;
    res = 0;
    for (int i = CSD_MAXD - 1; i >= 0; i--) begin
      if (nz[i]) begin
        if (n == k) res = i;
        n++;
      end
    end
    return res;
  endfunction

  // Sign of the k-th nonzero digit from the top (1 = negative).
  function automatic bit csd_nth_neg(input int unsigned coef, input int k);
    logic [2*CSD_MAXD-1:0] r;
    int p;
    r = csd_recode(coef);
    p = csd_nth_pos(coef, k);
    return r[CSD_MAXD + p];
  endfunction

endpackage

// File: rtl/csdm_framer.sv
// Frame position counter and serial sign extension of the input word.
module csdm_framer #(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 21,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_start,
  input  logic             ser_in,
  output logic             xe,
  output logic [CNT_W-1:0] phase,
  output logic             in_frame
);

  logic [CNT_W-1:0] pos_q;
  logic             sign_q;

  always_comb begin
    phase    = word_start ? '0 : pos_q;
    in_frame = (phase < CNT_W'(OUT_W));
    xe       = (phase < CNT_W'(DATA_W)) ? ser_in : sign_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= CNT_W'(OUT_W);
      sign_q <= 1'b0;
    end else begin
      if (in_frame) pos_q <= phase + CNT_W'(1);
      else          pos_q <= CNT_W'(OUT_W);
      if (phase == CNT_W'(DATA_W - 1)) sign_q <= ser_in;
    end
  end

endmodule

// File: rtl/csdm_shift_stage.sv
// GAP single-flip-flop shifts; reads as zero until GAP cycles of the frame have passed.
module csdm_shift_stage #(
  parameter int GAP   = 2,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             d,
  input  logic [CNT_W-1:0] phase,
  output logic             q
);

  logic [GAP-1:0] sr;

  generate
    if (GAP == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr <= '0;
        else     sr <= {sr[GAP-2:0], d};
      end
    end
  endgenerate

  assign q = (phase >= CNT_W'(GAP)) ? sr[GAP-1] : 1'b0;

endmodule

// File: rtl/csdm_serial_addsub.sv
// One bit-serial adder (SUB=0) or subtractor a-b (SUB=1) with a single carry flip-flop.
module csdm_serial_addsub #(
  parameter bit SUB = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic a,
  input  logic b,
  output logic s
);

  logic c_q;
  logic b_x;
  logic c_in;

  always_comb begin
    b_x  = b ^ SUB;
    c_in = start ? SUB : c_q;
    s    = a ^ b_x ^ c_in;
  end

  always_ff @(posedge clk) begin
    if (rst) c_q <= 1'b0;
    else     c_q <= (a & b_x) | (a & c_in) | (b_x & c_in);
  end

endmodule

// File: rtl/csd_serial_mult.sv
module csd_serial_mult
  import csdm_pkg::*;
#(
  parameter int          DATA_W = 8,
  parameter int          COEF_W = 12,
  parameter int unsigned COEF   = 2813
) (
  input  logic clk,
  input  logic rst,
  input  logic word_start,
  input  logic ser_in,
  output logic prod_out,
  output logic prod_first,
  output logic prod_valid
);

  localparam int DIG_N   = COEF_W + 1;
  localparam int OUT_W   = DATA_W + DIG_N;
  localparam int CNT_W   = $clog2(OUT_W + 1);
  localparam int TERMS   = csd_terms(COEF);
  localparam int LOW_POS = csd_nth_pos(COEF, TERMS - 1);

  logic             xe;
  logic             in_frame;
  logic [CNT_W-1:0] phase;
  logic [TERMS-1:0] acc;
  logic             y;

  csdm_framer #(
    .DATA_W(DATA_W),
    .OUT_W (OUT_W),
    .CNT_W (CNT_W)
  ) u_framer (
    .clk       (clk),
    .rst       (rst),
    .word_start(word_start),
    .ser_in    (ser_in),
    .xe        (xe),
    .phase     (phase),
    .in_frame  (in_frame)
  );

  // The top digit is always positive: the chain starts from the input itself.
  assign acc[0] = xe;

  // Horner chain: shift the partial product down to the next digit, then add or subtract x.
  generate
    for (genvar k = 1; k < TERMS; k++) begin : g_term
      localparam int GAP = csd_nth_pos(COEF, k - 1) - csd_nth_pos(COEF, k);
      localparam bit NEG = csd_nth_neg(COEF, k);
      logic shf;

      csdm_shift_stage #(
        .GAP  (GAP),
        .CNT_W(CNT_W)
      ) u_shift (
        .clk  (clk),
        .rst  (rst),
        .d    (acc[k-1]),
        .phase(phase),
        .q    (shf)
      );

      csdm_serial_addsub #(
        .SUB(NEG)
      ) u_add (
        .clk  (clk),
        .rst  (rst),
        .start(word_start),
        .a    (shf),
        .b    (xe),
        .s    (acc[k])
      );
    end

    if (LOW_POS > 0) begin : g_tail
      csdm_shift_stage #(
        .GAP  (LOW_POS),
        .CNT_W(CNT_W)
      ) u_tail (
        .clk  (clk),
        .rst  (rst),
        .d    (acc[TERMS-1]),
        .phase(phase),
        .q    (y)
      );
    end else begin : g_notail
      assign y = acc[TERMS-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_out   <= 1'b0;
      prod_first <= 1'b0;
      prod_valid <= 1'b0;
    end else begin
      prod_out   <= in_frame & y;
      prod_first <= word_start;
      prod_valid <= in_frame;
    end
  end

endmodule

// File: rtl/csd_serial_mult_chk.sv
module csd_serial_mult_chk #(
  parameter int OUT_W = 21
) (
  input logic clk,
  input logic rst,
  input logic word_start,
  input logic prod_out,
  input logic prod_first,
  input logic prod_valid
);

  int cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= OUT_W;
    else if (prod_first)    cnt_q <= 1;
    else if (cnt_q < OUT_W) cnt_q <= cnt_q + 1;
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!prod_valid && !prod_first && !prod_out));

  a_r2_first_follows_start: assert property (@(posedge clk) disable iff (rst)
    word_start |=> prod_first);

  a_r2_first_needs_start: assert property (@(posedge clk) disable iff (rst)
    prod_first |-> $past(word_start));

  a_r3_valid_window: assert property (@(posedge clk) disable iff (rst)
    prod_valid == (prod_first || (cnt_q < OUT_W)));

  a_r3_idle_low: assert property (@(posedge clk) disable iff (rst)
    !prod_valid |-> !prod_out);

endmodule

bind csd_serial_mult csd_serial_mult_chk #(.OUT_W(OUT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .word_start(word_start),
  .prod_out  (prod_out),
  .prod_first(prod_first),
  .prod_valid(prod_valid)
);

// File: tb/test_csd_serial_mult.sv
`timescale 1ns/1ps
module test_csd_serial_mult;

  localparam int DATA_W = 8;
  localparam int OUT_W  = DATA_W + 13;
  localparam int MAXF   = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic word_start = 1'b0;
  logic ser_in = 1'b0;
  logic [2:0] po, pf, pv;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  csd_serial_mult #(.DATA_W(DATA_W), .COEF_W(12), .COEF(2813)) i_csd_serial_mult (
    .clk(clk), .rst(rst), .word_start(word_start), .ser_in(ser_in),
    .prod_out(po[0]), .prod_first(pf[0]), .prod_valid(pv[0]));

  csd_serial_mult #(.DATA_W(DATA_W), .COEF_W(12), .COEF(1)) i_csd_serial_mult_c1 (
    .clk(clk), .rst(rst), .word_start(word_start), .ser_in(ser_in),
    .prod_out(po[1]), .prod_first(pf[1]), .prod_valid(pv[1]));

  csd_serial_mult #(.DATA_W(DATA_W), .COEF_W(12), .COEF(4095)) i_csd_serial_mult_c4095 (
    .clk(clk), .rst(rst), .word_start(word_start), .ser_in(ser_in),
    .prod_out(po[2]), .prod_first(pf[2]), .prod_valid(pv[2]));

  function automatic longint coef_of(input int d);
    if (d == 0) return 2813;
    if (d == 1) return 1;
    return 4095;
  endfunction

  // Collector: rebuilds product words from the serial outputs.
  logic [OUT_W-1:0] got [3][MAXF];
  logic [OUT_W-1:0] acc [3];
  int  ngot [3];
  int  aborted [3];
  int  bad_len [3];
  int  bitn [3];
  bit  in_word [3];

  initial begin
    for (int d = 0; d < 3; d++) begin
      ngot[d] = 0; aborted[d] = 0; bad_len[d] = 0; bitn[d] = 0; in_word[d] = 1'b0; acc[d] = '0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      for (int d = 0; d < 3; d++) begin
        if (pv[d]) begin
          if (pf[d]) begin
            if (in_word[d]) aborted[d]++;
            in_word[d] = 1'b1;
            bitn[d]    = 0;
            acc[d]     = '0;
          end
          if (in_word[d]) begin
            acc[d][bitn[d]] = po[d];
            bitn[d]++;
            if (bitn[d] == OUT_W) begin
              if (ngot[d] < MAXF) got[d][ngot[d]] = acc[d];
              ngot[d]++;
              in_word[d] = 1'b0;
            end
          end
        end else if (in_word[d]) begin
          bad_len[d]++;
          in_word[d] = 1'b0;
        end
      end
    end
  end

  // Expected inputs of completed words, in order.
  logic [DATA_W-1:0] ex [MAXF];
  int nexp = 0;
  int ncmp = 0;

  task automatic check_val(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive_word(input logic [DATA_W-1:0] x, input int ncyc, input bit junk, input bit record);
    for (int t = 0; t < ncyc; t++) begin
      @(negedge clk);
      word_start = (t == 0);
      if (t < DATA_W) ser_in = x[t];
      else            ser_in = junk ? 1'($urandom) : 1'b0;
    end
    if (record) begin
      ex[nexp] = x;
      nexp++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      word_start = 1'b0;
      ser_in     = 1'($urandom);
    end
  endtask

  task automatic compare_all(input string req);
    for (int d = 0; d < 3; d++) begin
      check_val({req, " word count"}, ngot[d], nexp);
      for (int i = ncmp; i < nexp && i < ngot[d]; i++) begin
        longint p;
        logic [OUT_W-1:0] e;
        p = longint'($signed(ex[i])) * coef_of(d);
        e = p[OUT_W-1:0];
        checks++;
        if (got[d][i] !== e) begin
          failures++;
          $display("FAIL %s coef=%0d x=%0d actual=%h expected=%h",
                   req, coef_of(d), $signed(ex[i]), got[d][i], e);
        end
      end
    end
    ncmp = nexp;
  endtask

  // R1: reset quiets outputs; idle input after reset has no effect.
  task automatic t_reset();
    rst = 1'b1; word_start = 1'b1; ser_in = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R1 outputs in reset", {29'd0, po | pf | pv}, 0);
    rst = 1'b0; word_start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ser_in = 1'($urandom);
      check_val("R1 outputs idle after reset", {29'd0, po | pf | pv}, 0);
    end
  endtask

  // R2: first product bit one cycle after word_start, marked by prod_first.
  task automatic t_latency();
    logic [DATA_W-1:0] x;
    x = 8'd1;
    @(negedge clk);
    word_start = 1'b1; ser_in = x[0];
    check_val("R2 no marker before start", {29'd0, pf}, 0);
    @(negedge clk);
    check_val("R2 marker one cycle after start", {29'd0, pf}, 7);
    check_val("R2 bit0 of product", {29'd0, po}, 7);
    word_start = 1'b0; ser_in = x[1];
    for (int t = 2; t < OUT_W; t++) begin
      @(negedge clk);
      ser_in = (t < DATA_W) ? x[t] : 1'b0;
    end
    ex[nexp] = x; nexp++;
    idle(3);
    compare_all("R2");
  endtask

  task automatic t_basic();
    drive_word(8'd0, OUT_W, 0, 1);   idle(2);
    drive_word(8'd1, OUT_W, 0, 1);   idle(2);
    drive_word(8'hFF, OUT_W, 0, 1);  idle(2);
    drive_word(8'd127, OUT_W, 0, 1); idle(2);
    drive_word(8'h80, OUT_W, 0, 1);  idle(2);
    drive_word(8'd5, OUT_W, 0, 1);   idle(3);
    compare_all("R4");
  endtask

  // R5: random bits in the extension cycles.
  task automatic t_junk();
    drive_word(8'h80, OUT_W, 1, 1); idle(1);
    drive_word(8'h7F, OUT_W, 1, 1); idle(1);
    for (int i = 0; i < 4; i++) begin
      drive_word(8'($urandom), OUT_W, 1, 1);
      idle(1);
    end
    idle(2);
    compare_all("R5");
  endtask

  // R6: back-to-back words, extreme signs alternating.
  task automatic t_b2b();
    drive_word(8'h80, OUT_W, 1, 1);
    drive_word(8'h7F, OUT_W, 1, 1);
    drive_word(8'h80, OUT_W, 1, 1);
    drive_word(8'h01, OUT_W, 1, 1);
    drive_word(8'hFF, OUT_W, 1, 1);
    drive_word(8'h00, OUT_W, 1, 1);
    drive_word(8'($urandom), OUT_W, 1, 1);
    drive_word(8'($urandom), OUT_W, 1, 1);
    idle(3);
    compare_all("R6");
  endtask

  // R7: restart in the middle of a frame.
  task automatic t_restart();
    int ab0;
    ab0 = aborted[0];
    drive_word(8'h80, 6, 0, 0);
    drive_word(8'h35, OUT_W, 1, 1);
    idle(3);
    for (int d = 0; d < 3; d++)
      check_val("R7 abandoned word counted", aborted[d] - ab0, 1);
    compare_all("R7");
  endtask

  // R8: all three coefficients across random words, with random gaps.
  task automatic t_random();
    for (int i = 0; i < 30; i++) begin
      drive_word(8'($urandom), OUT_W, 1, 1);
      idle($urandom_range(0, 2));
    end
    idle(3);
    compare_all("R8");
  endtask

  initial begin
    t_reset();
    t_latency();
    t_basic();
    t_junk();
    t_b2b();
    t_restart();
    t_random();
    for (int d = 0; d < 3; d++)
      check_val("R3 short valid windows", bad_len[d], 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule